// File: doc/BRIEF.md
# Flash Bus Mode and Reset Controller

This block is the control side of a parallel NOR-style flash device. It watches four active-low control pins: chip select, output enable, write enable and a reset/power-down pin. From them it decides whether the 16-bit data bus is driven, which read view is presented (array words, identifier codes or status) and whether the part is in standby or deep power-down. Commands are written on the falling edge of write enable. They select the read view or start a word program or a whole-array erase. A small register-backed word array and a busy-cycle counter stand in for the real storage and its slow algorithms.

The power-down pin acts as a filtered reset. A low pulse counts only if it lasts a minimum number of clock cycles. An accepted pulse puts the command interface back into array-read mode and resets the status byte to 0x80. If an erase or program is running, the pulse aborts it and holds the busy indication until the wake-up sequence has run. After the pin returns high, two separate wake-up windows must pass: one before read data is valid and a longer one before a new command is accepted.

Top module: `flash_ctrl_top`

## Requirements
- R1: With output enable high, the bus enable output is 0 and the data output is 0x0000 one clock later.
- R2: The bus is driven, one clock after sampling, only when chip select, output enable and write enable read low, low and high, the power-down pin is high, the device is not powered down and the read wake-up window has elapsed. In every other case the bus is released, including whenever chip select is high.
- R3: An erase or program that is running completes and updates the array even if chip select goes high while it runs.
- R4: Power-down is entered on the edge where the power-down pin has been sampled low for MIN_PD consecutive clocks. A shorter low pulse changes no mode or operation.
- R5: Entering power-down returns the read view to array mode. The status view reads 0x80 when idle and 0x00 while busy (bit 7 is ready).
- R6: Power-down entered while an operation is busy cancels it, and the target words keep their old contents. The ready output stays low until the read wake-up window has elapsed.
- R7: After the power-down pin returns high, reads stay released until the wake counter has run T_READ clocks.
- R8: After the power-down pin returns high, command writes are ignored until the wake counter has run T_CMD clocks.
- R9: In identifier view, address 0x00000 reads 0x005A, address 0x00001 reads 0x00C3 and all other addresses up to 0x7FFFF read 0x0000.
- R10: Command bytes (low 8 bits of the write data) are decoded as follows: 0xFF selects array view, 0x90 selects identifier view, 0x70 selects status view, 0x40 arms a word program and 0x20 arms an erase. Any other byte written while nothing is armed is ignored.
- R11: The write that follows 0x40 programs word addr[3:0] with the bitwise AND of its old value and the data. Ready goes low for OP_CYCLES clocks, and the view switches to status.
- R12: 0x20 followed by 0xD0 erases every word to 0xFFFF after OP_CYCLES busy clocks. 0x20 followed by any other byte cancels the erase and selects array view. Array words are 0xFFFF after system reset.
- R13: A write is taken on a clock where write enable is sampled low after being high, with chip select low. Address and data are sampled in the same clock. Writes while busy or aborting are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| pwr_n | input | 1 | Reset / deep power-down pin, active low |
| addr | input | 19 | Word address |
| wdata | input | 16 | Command or program data |
| rdata_o | output | 16 | Read data, 0 when not driven |
| rdata_oe_o | output | 1 | Bus drive enable for the tri-state pad |
| ready_o | output | 1 | High when idle, low while busy or aborting |

## Verification
The hardest case to reach is a power-down pulse that lands during a program. It must be long enough to be accepted, and it is followed by a command written inside the gap between the read and command wake-up windows. The stimulus starts a program, lowers the power-down pin for a few clocks more than the minimum while the busy counter is mid-count, then raises it. It tries a read on the very next clock and writes an identifier command a clock later. A behavioural model in the bench, stepped on every clock, shows the read released, the command ignored, the ready output low until the read window ends, and the targeted word unchanged.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

    typedef enum logic [1:0] {
        VIEW_ARRAY  = 2'd0,
        VIEW_IDENT  = 2'd1,
        VIEW_STATUS = 2'd2
    } view_e;

    typedef enum logic [1:0] {
        ARM_NONE  = 2'd0,
        ARM_ERASE = 2'd1,
        ARM_PROG  = 2'd2
    } arm_e;

    localparam logic [7:0] OPC_VIEW_ARRAY  = 8'hFF;
    localparam logic [7:0] OPC_VIEW_IDENT  = 8'h90;
    localparam logic [7:0] OPC_VIEW_STATUS = 8'h70;
    localparam logic [7:0] OPC_ARM_PROG    = 8'h40;
    localparam logic [7:0] OPC_ARM_ERASE   = 8'h20;
    localparam logic [7:0] OPC_CONFIRM     = 8'hD0;

    localparam logic [15:0] MAKER_CODE = 16'h005A;
    localparam logic [15:0] PART_CODE  = 16'h00C3;

endpackage

// File: rtl/flash_pd_seq.sv
module flash_pd_seq #(
    parameter int MIN_PD = 4,
    parameter int T_READ = 3,
    parameter int T_CMD  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_n,
    output logic pd_o,
    output logic enter_o,
    output logic read_ok_o,
    output logic cmd_ok_o
);
    localparam int WMAX = (T_READ > T_CMD) ? T_READ : T_CMD;
    localparam int CW   = $clog2(WMAX + 1);
    localparam int LW   = (MIN_PD > 1) ? $clog2(MIN_PD) : 1;
    localparam logic [CW-1:0] WMAX_C  = CW'(WMAX);
    localparam logic [CW-1:0] TREAD_C = CW'(T_READ);
    localparam logic [CW-1:0] TCMD_C  = CW'(T_CMD);
    localparam logic [LW-1:0] LMAX_C  = LW'(MIN_PD - 1);

    typedef struct packed {
        logic          pd;
        logic          waking;
        logic [LW-1:0] lo;
        logic [CW-1:0] wc;
    } pd_state_t;

    pd_state_t s_q, s_d;
    logic enter;

    always_comb begin
        s_d   = s_q;
        enter = !pwr_n && !s_q.pd && (s_q.lo == LMAX_C);
        if (pwr_n) begin
            s_d.lo = '0;
        end else if (s_q.lo != LMAX_C) begin
            s_d.lo = s_q.lo + LW'(1);
        end
        if (enter) begin
            s_d.pd     = 1'b1;
            s_d.waking = 1'b0;
            s_d.wc     = '0;
        end else if (s_q.pd && pwr_n) begin
            s_d.pd     = 1'b0;
            s_d.waking = 1'b1;
            s_d.wc     = '0;
        end else if (s_q.waking) begin
            if (s_q.wc == WMAX_C) begin
                s_d.waking = 1'b0;
            end else begin
                s_d.wc = s_q.wc + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pd_o      = s_q.pd;
    assign enter_o   = enter;
    assign read_ok_o = !s_q.pd && (!s_q.waking || (s_q.wc >= TREAD_C));
    assign cmd_ok_o  = !s_q.pd && (!s_q.waking || (s_q.wc >= TCMD_C));

    // R4
    pd_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pd) |-> $past(!pwr_n));

    // R7
    wake_read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.pd) |-> !read_ok_o);

    // R8
    cmd_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok_o && (T_CMD >= T_READ) |-> read_ok_o);

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb_i,
    input  logic [7:0] cmd_i,
    input  logic       pd_enter_i,
    output view_e      view_o,
    output logic       start_erase_o,
    output logic       start_prog_o
);
    typedef struct packed {
        view_e view;
        arm_e  arm;
    } cmd_state_t;

    cmd_state_t s_q, s_d;
    logic start_erase, start_prog;

    always_comb begin
        s_d         = s_q;
        start_erase = 1'b0;
        start_prog  = 1'b0;
        if (pd_enter_i) begin
            s_d.view = VIEW_ARRAY;
            s_d.arm  = ARM_NONE;
        end else if (wr_stb_i) begin
            unique case (s_q.arm)
                ARM_PROG: begin
                    start_prog = 1'b1;
                    s_d.arm    = ARM_NONE;
                    s_d.view   = VIEW_STATUS;
                end
                ARM_ERASE: begin
                    s_d.arm = ARM_NONE;
                    if (cmd_i == OPC_CONFIRM) begin
                        start_erase = 1'b1;
                        s_d.view    = VIEW_STATUS;
                    end else begin
                        s_d.view = VIEW_ARRAY;
                    end
                end
                default: begin
                    case (cmd_i)
                        OPC_VIEW_ARRAY:  s_d.view = VIEW_ARRAY;
                        OPC_VIEW_IDENT:  s_d.view = VIEW_IDENT;
                        OPC_VIEW_STATUS: s_d.view = VIEW_STATUS;
                        OPC_ARM_PROG:    s_d.arm  = ARM_PROG;
                        OPC_ARM_ERASE:   s_d.arm  = ARM_ERASE;
                        default:         s_d      = s_q;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{view: VIEW_ARRAY, arm: ARM_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign view_o        = s_q.view;
    assign start_erase_o = start_erase;
    assign start_prog_o  = start_prog;

    // R5
    pd_view_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_enter_i |=> (s_q.view == VIEW_ARRAY && s_q.arm == ARM_NONE));

    // R10
    one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_erase, start_prog}));

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine #(
    parameter int WORDS     = 16,
    parameter int DW        = 16,
    parameter int OP_CYCLES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_erase_i,
    input  logic                       start_prog_i,
    input  logic [$clog2(WORDS)-1:0]   prog_idx_i,
    input  logic [DW-1:0]              prog_data_i,
    input  logic                       pd_enter_i,
    input  logic                       read_ok_i,
    input  logic [$clog2(WORDS)-1:0]   rd_idx_i,
    output logic [DW-1:0]              rd_word_o,
    output logic                       busy_o,
    output logic                       ready_o
);
    localparam int IW = $clog2(WORDS);
    localparam int BW = $clog2(OP_CYCLES + 1);
    localparam logic [BW-1:0] OPC_C = BW'(OP_CYCLES);

    typedef struct packed {
        logic [BW-1:0] cnt;
        logic          erase;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
        logic          abort;
    } op_state_t;

    op_state_t  s_q, s_d;
    logic [DW-1:0] mem_q [WORDS];
    logic [DW-1:0] mem_d [WORDS];
    logic busy;

    assign busy = (s_q.cnt != '0);

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (pd_enter_i && busy) begin
            s_d.cnt   = '0;
            s_d.abort = 1'b1;
        end else if (busy) begin
            s_d.cnt = s_q.cnt - BW'(1);
            if (s_q.cnt == BW'(1)) begin
                if (s_q.erase) begin
                    for (int i = 0; i < WORDS; i++) begin
                        mem_d[i] = '1;
                    end
                end else begin
                    mem_d[s_q.idx] = mem_q[s_q.idx] & s_q.data;
                end
            end
        end else if (start_erase_i || start_prog_i) begin
            s_d.cnt   = OPC_C;
            s_d.erase = start_erase_i;
            s_d.idx   = prog_idx_i;
            s_d.data  = prog_data_i;
        end
        if (!(pd_enter_i && busy) && s_q.abort && read_ok_i) begin
            s_d.abort = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            s_q <= s_d;
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_word_o = mem_q[rd_idx_i];
    assign busy_o    = busy;
    assign ready_o   = !busy && !s_q.abort;

    // R6
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_enter_i && busy) |=> (!busy && !ready_o));

    // R11
    busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pd_enter_i) |=> (s_q.cnt == $past(s_q.cnt) - BW'(1)));

    // R6
    abort_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_enter_i && busy && !s_q.erase) |=> $stable(mem_q[s_q.idx]));

endmodule

// File: rtl/flash_ctrl_top.sv
module flash_ctrl_top
    import flash_ctrl_pkg::*;
#(
    parameter int AW        = 19,
    parameter int DW        = 16,
    parameter int WORDS     = 16,
    parameter int OP_CYCLES = 8,
    parameter int MIN_PD    = 4,
    parameter int T_READ    = 3,
    parameter int T_CMD     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_sel_n,
    input  logic          out_en_n,
    input  logic          wr_en_n,
    input  logic          pwr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_o,
    output logic          rdata_oe_o,
    output logic          ready_o
);
    localparam int IW = $clog2(WORDS);

    typedef struct packed {
        logic          we_prev;
        logic          oe;
        logic [DW-1:0] data;
    } bus_state_t;

    bus_state_t s_q, s_d;

    logic pd, pd_enter, read_ok, cmd_ok;
    logic busy, ready;
    logic wr_stb, start_erase, start_prog;
    logic [DW-1:0] arr_word;
    view_e view;

    flash_pd_seq #(
        .MIN_PD (MIN_PD),
        .T_READ (T_READ),
        .T_CMD  (T_CMD)
    ) u_pd (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_n     (pwr_n),
        .pd_o      (pd),
        .enter_o   (pd_enter),
        .read_ok_o (read_ok),
        .cmd_ok_o  (cmd_ok)
    );

    flash_cmd_fsm u_cmd (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_stb_i      (wr_stb),
        .cmd_i         (wdata[7:0]),
        .pd_enter_i    (pd_enter),
        .view_o        (view),
        .start_erase_o (start_erase),
        .start_prog_o  (start_prog)
    );

    flash_op_engine #(
        .WORDS     (WORDS),
        .DW        (DW),
        .OP_CYCLES (OP_CYCLES)
    ) u_op (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_erase_i (start_erase),
        .start_prog_i  (start_prog),
        .prog_idx_i    (addr[IW-1:0]),
        .prog_data_i   (wdata),
        .pd_enter_i    (pd_enter),
        .read_ok_i     (read_ok),
        .rd_idx_i      (addr[IW-1:0]),
        .rd_word_o     (arr_word),
        .busy_o        (busy),
        .ready_o       (ready)
    );

    assign wr_stb = !chip_sel_n && !wr_en_n && s_q.we_prev && pwr_n &&
                    !pd && cmd_ok && ready;

    always_comb begin
        logic drive;
        logic [DW-1:0] word;
        s_d         = s_q;
        s_d.we_prev = wr_en_n;
        drive = !chip_sel_n && !out_en_n && wr_en_n && pwr_n && read_ok;
        unique case (view)
            VIEW_IDENT: begin
                if (addr == AW'(0)) begin
                    word = MAKER_CODE;
                end else if (addr == AW'(1)) begin
                    word = PART_CODE;
                end else begin
                    word = '0;
                end
            end
            VIEW_STATUS: word = {{(DW-8){1'b0}}, ready, 7'b0};
            default:     word = arr_word;
        endcase
        s_d.oe   = drive;
        s_d.data = drive ? word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{we_prev: 1'b1, oe: 1'b0, data: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o    = s_q.data;
    assign rdata_oe_o = s_q.oe;
    assign ready_o    = ready;

    // R1
    oe_high_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |=> !rdata_oe_o);

    // R2
    cs_high_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel_n |=> (!rdata_oe_o && rdata_o == '0));

    // R2
    pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> !rdata_oe_o);

    // R13
    busy_write_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_stb);

endmodule

// File: tb/tb_flash_ctrl_top.sv
`timescale 1ns/1ps
module tb_flash_ctrl_top;
    localparam int OPC  = 8;
    localparam int MPD  = 4;
    localparam int TRD  = 3;
    localparam int TCM  = 6;
    localparam int WMAX = (TRD > TCM) ? TRD : TCM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pw_n = 1'b1;
    logic [18:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic rdata_oe, ready;

    always #2.5 clk = ~clk;

    flash_ctrl_top dut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(cs_n), .out_en_n(oe_n),
        .wr_en_n(we_n), .pwr_n(pw_n), .addr(addr), .wdata(wdata),
        .rdata_o(rdata), .rdata_oe_o(rdata_oe), .ready_o(ready)
    );

    int checks = 0, errors = 0;
    string tag = "R2";
    bit done = 0;

    // behavioural reference model
    int m_view, m_arm, m_busy, m_kind, m_idx, m_dat, m_lo, m_wc;
    bit m_pd, m_wake, m_abort, m_weprev;
    int mem[16];
    bit e_oe, e_rdy;
    int e_data;

    task automatic chk(input bit ok, input int act, input int exp, input string r);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_view = 0; m_arm = 0; m_busy = 0; m_kind = 0; m_idx = 0; m_dat = 0;
            m_lo = 0; m_wc = 0; m_pd = 0; m_wake = 0; m_abort = 0; m_weprev = 1;
            foreach (mem[i]) mem[i] = 'hFFFF;
            e_oe = 0; e_data = 0; e_rdy = 1;
        end else begin
            bit rd_ok, cm_ok, rdy, stb, ent;
            int word;
            rd_ok = !m_pd && (!m_wake || m_wc >= TRD);
            cm_ok = !m_pd && (!m_wake || m_wc >= TCM);
            rdy   = (m_busy == 0) && !m_abort;
            e_oe  = !cs_n && !oe_n && we_n && pw_n && rd_ok;
            if (m_view == 1) word = (addr == 0) ? 'h005A : (addr == 1) ? 'h00C3 : 0;
            else if (m_view == 2) word = rdy ? 'h80 : 0;
            else word = mem[addr[3:0]];
            e_data = e_oe ? word : 0;
            stb = !cs_n && !we_n && m_weprev && pw_n && cm_ok && rdy;
            ent = !pw_n && !m_pd && (m_lo == MPD - 1);
            // operation
            if (ent && m_busy > 0) begin
                m_busy = 0; m_abort = 1;
            end else begin
                if (m_busy > 0) begin
                    if (m_busy == 1) begin
                        if (m_kind == 1) foreach (mem[i]) mem[i] = 'hFFFF;
                        else mem[m_idx] = mem[m_idx] & m_dat;
                    end
                    m_busy--;
                end
                if (m_abort && rd_ok) m_abort = 0;
            end
            // commands
            if (ent) begin
                m_view = 0; m_arm = 0;
            end else if (stb) begin
                if (m_arm == 2) begin
                    m_arm = 0; m_view = 2; m_busy = OPC; m_kind = 0;
                    m_idx = addr[3:0]; m_dat = wdata;
                end else if (m_arm == 1) begin
                    m_arm = 0;
                    if (wdata[7:0] == 8'hD0) begin
                        m_view = 2; m_busy = OPC; m_kind = 1;
                    end else m_view = 0;
                end else begin
                    case (wdata[7:0])
                        8'hFF: m_view = 0;
                        8'h90: m_view = 1;
                        8'h70: m_view = 2;
                        8'h40: m_arm = 2;
                        8'h20: m_arm = 1;
                        default: ;
                    endcase
                end
            end
            // power-down sequence
            if (pw_n) m_lo = 0; else if (m_lo < MPD - 1) m_lo++;
            if (ent) begin
                m_pd = 1; m_wake = 0; m_wc = 0;
            end else if (m_pd && pw_n) begin
                m_pd = 0; m_wake = 1; m_wc = 0;
            end else if (m_wake) begin
                if (m_wc == WMAX) m_wake = 0; else m_wc++;
            end
            m_weprev = we_n;
            e_rdy = (m_busy == 0) && !m_abort;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rdata_oe == e_oe, rdata_oe, e_oe, {tag, " bus enable"});
            chk(rdata == e_data[15:0], rdata, e_data, {tag, " data"});
            chk(ready == e_rdy, ready, e_rdy, {tag, " ready"});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); cs_n = 0; oe_n = 1; we_n = 0; addr = a[18:0]; wdata = d[15:0];
        @(negedge clk); we_n = 1;
    endtask

    task automatic rd_chk(input int a, input int exp, input string r);
        @(negedge clk); cs_n = 0; oe_n = 0; we_n = 1; addr = a[18:0];
        @(negedge clk); #0.5;
        chk(rdata_oe && rdata == exp[15:0], rdata, exp, r);
        oe_n = 1;
    endtask

    initial begin
        cyc(4);
        rst_n = 1;
        cyc(1); #0.5;
        chk(!rdata_oe && ready, {rdata_oe, ready}, 1, "R5 reset state");
        tag = "R12"; rd_chk(0, 'hFFFF, "R12 erased after reset");
        tag = "R11"; wr(0, 'h40); wr(3, 'h1234);
        #0.5; chk(!ready, ready, 0, "R11 busy after program");
        cyc(OPC + 2); wr(0, 'hFF); rd_chk(3, 'h1234, "R11 program");
        wr(0, 'h40); wr(3, 'hFF0F); cyc(OPC + 2); wr(0, 'hFF);
        rd_chk(3, 'h1204, "R11 AND program");
        tag = "R9"; wr(0, 'h90);
        rd_chk(0, 'h005A, "R9 maker code"); rd_chk(1, 'h00C3, "R9 part code");
        rd_chk(2, 0, "R9 reserved low"); rd_chk('h7FFFF, 0, "R9 reserved top");
        tag = "R10"; wr(0, 'h70); rd_chk(0, 'h80, "R10 status view");
        tag = "R1"; @(negedge clk); cs_n = 0; oe_n = 1;
        @(negedge clk); #0.5; chk(!rdata_oe, rdata_oe, 0, "R1 oe high");
        tag = "R2"; @(negedge clk); cs_n = 1; oe_n = 0;
        @(negedge clk); #0.5; chk(!rdata_oe, rdata_oe, 0, "R2 cs high");
        @(negedge clk); cs_n = 0; we_n = 0; wdata = 0;
        @(negedge clk); #0.5; chk(!rdata_oe, rdata_oe, 0, "R2 we low");
        we_n = 1; oe_n = 1;
        tag = "R13"; wr(0, 'h40); wr(7, 'h0F0F); wr(0, 'h90); cyc(OPC + 2);
        rd_chk(0, 'h80, "R13 write ignored while busy");
        wr(0, 'hFF); rd_chk(7, 'h0F0F, "R13 program data");
        tag = "R3"; wr(0, 'h40); wr(8, 'h3333);
        @(negedge clk); cs_n = 1; cyc(OPC + 3); #0.5;
        chk(ready, ready, 1, "R3 done with cs high");
        wr(0, 'hFF); rd_chk(8, 'h3333, "R3 committed");
        tag = "R4"; wr(0, 'h90); wr(0, 'h40); wr(9, 'h0000);
        @(negedge clk); pw_n = 0; cyc(MPD - 1); pw_n = 1; #0.5;
        chk(!ready, ready, 0, "R4 short pulse keeps busy");
        cyc(OPC + 2); wr(0, 'hFF); rd_chk(9, 0, "R4 short pulse ignored");
        tag = "R6"; wr(0, 'h40); wr(5, 'h0000); cyc(2);
        @(negedge clk); pw_n = 0; cyc(MPD + 2); #0.5;
        chk(!ready, ready, 0, "R6 ready low in power-down");
        tag = "R7"; cs_n = 0; oe_n = 0; pw_n = 1;
        @(negedge clk); #0.5; chk(!rdata_oe, rdata_oe, 0, "R7 read gated");
        chk(!ready, ready, 0, "R6 ready low while waking");
        oe_n = 1;
        tag = "R8"; wr(0, 'h90); cyc(WMAX + 3); #0.5;
        chk(ready, ready, 1, "R6 ready after wake");
        rd_chk(0, 'hFFFF, "R8 early command ignored");
        rd_chk(5, 'hFFFF, "R6 aborted word unchanged");
        tag = "R5"; wr(0, 'h70); rd_chk(0, 'h80, "R5 status after power-down");
        tag = "R12"; wr(0, 'h20); wr(0, 'hD0); cyc(OPC + 2); wr(0, 'hFF);
        rd_chk(3, 'hFFFF, "R12 erase"); rd_chk(9, 'hFFFF, "R12 erase other");
        wr(0, 'h40); wr(3, 'h00F0); cyc(OPC + 2); wr(0, 'h20); wr(0, 'h11);
        rd_chk(3, 'h00F0, "R12 cancelled erase");
        cyc(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule